// File: doc/BRIEF.md
# Processor reset qualification sequencer

This block sits between the board-level reset and halt requests and a simple 16-bit processor core. It decides when an external reset request is genuine and when it has to be ignored. Reset and halt pulled low together must last a short window to be accepted. Reset pulled low alone must last a much longer window, and that path only opens once a first full start-up has completed. While the core is running a software reset instruction, the block drives its own active-low reset output, and it ignores the reset input for as long as that output is low.

Once a reset is accepted, the block holds the core in reset, waits through a fixed start-up delay and then reads four 16-bit vector words over a simple request/acknowledge bus. The four words are the upper and lower halves of the stack pointer, followed by the upper and lower halves of the program counter. After the fourth word it pulses a first-fetch strobe and releases the core. The latched stack pointer and program counter appear on the outputs only after the sequence has completed. If a new accepted reset arrives part-way through, the sequence starts again from the delay.

Top module: `rst_qual_seq`

## Requirements
- R1: During synchronous reset and in the cycle after it: rst_out_n=1, core_in_reset=1, partial_rst=0, rd_req=0, fetch_req=0, sp_out=0 and pc_out=0.
- R2: When ext_rst_n and ext_halt_n are both sampled low on FULL_QUAL (10) consecutive rising edges, the reset is accepted on the last of those edges, and core_in_reset is 1 after that edge. A shorter run is not accepted.
- R3: When ext_rst_n is sampled low with ext_halt_n high on SOLO_QUAL (132) consecutive edges, the reset is accepted, but only once a start-up sequence has run to its first fetch. Before that, a reset-only request of any length is never accepted.
- R4: While rst_out_n is 0, a reset-only request on the input is ignored and its counter does not advance.
- R5: If both inputs are sampled low while rst_out_n is 0, rst_out_n returns to 1 after that edge. If the pair then drops before FULL_QUAL further edges, partial_rst becomes 1 and nothing is accepted. The next accepted reset clears partial_rst.
- R6: A rising edge of sw_rst_active sampled while the core runs drives rst_out_n to 0 after that edge. rst_out_n returns to 1 after the first edge that samples bus_cycle_start=1 with sw_rst_active=0.
- R7: After an accepting edge the block waits STARTUP_DLY (4) cycles, so rd_req first rises after the fourth edge that follows it. It then reads byte addresses 0, 2, 4 and 6 in that order, and holds each address until bus_ack is sampled high.
- R8: fetch_req is 1 for a single cycle, and only after all four acknowledged reads. After the edge that follows it, core_in_reset=0, sp_out={word@0, word@2} and pc_out={word@4, word@6}.
- R9: While ext_rst_n is low and not ignored, rd_req and fetch_req are 0. sp_out and pc_out read 0 until the sequence has completed.
- R10: The qualification counters clear whenever their input condition is broken. Holding a request beyond its window gives exactly one acceptance: the start-up delay is not restarted.
- R11: An accepted reset in the middle of the vector reads aborts them. The sequence restarts with the delay and byte address 0, and the outputs show the newly read words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_rst_n | input | 1 | External reset request, active low |
| ext_halt_n | input | 1 | External halt request, active low |
| sw_rst_active | input | 1 | Core is executing a software reset instruction |
| bus_cycle_start | input | 1 | Core starts a new bus cycle |
| bus_ack | input | 1 | Acknowledge for the current vector read |
| bus_rdata | input | 16 | Read data for the current vector read |
| rst_out_n | output | 1 | Reset output driven by a software reset, active low |
| core_in_reset | output | 1 | Core is held in reset |
| partial_rst | output | 1 | Last reset attempt was partial and invalid |
| rd_req | output | 1 | Vector read request |
| rd_addr | output | ADDR_W | Byte address of the vector read |
| fetch_req | output | 1 | First instruction fetch strobe |
| sp_out | output | 32 | Latched stack pointer |
| pc_out | output | 32 | Latched program counter |

## Verification
An accepting edge is the FULL_QUAL-th or SOLO_QUAL-th consecutive sampled edge. core_in_reset is checked just after that edge and just after the one before it. rd_req is checked low on the three edges that follow release and high after the fourth edge counted from acceptance. rst_out_n and partial_rst change one edge after the input that causes them, so the bench drives and samples only at falling clock edges. Each check is placed that many falling edges after its stimulus. The hold-length sweeps cover both windows around their thresholds and also past them.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

    localparam int unsigned WORD_W    = 16;
    localparam int unsigned VEC_WORDS = 4;
    localparam int unsigned WORD_BYTES = WORD_W / 8;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [2:0] {
        SEQ_BOOT,
        SEQ_START,
        SEQ_VEC,
        SEQ_FETCH,
        SEQ_RUN
    } seq_state_e;

    typedef struct packed {
        word_t sp_hi;
        word_t sp_lo;
        word_t pc_hi;
        word_t pc_lo;
    } vec_set_t;

    function automatic int unsigned sat_next(input int unsigned cur, input int unsigned lim);
        return (cur >= lim) ? lim : cur + 1;
    endfunction

    function automatic int unsigned word_byte_addr(input int unsigned idx);
        return idx * WORD_BYTES;
    endfunction

endpackage

// File: rtl/rsq_qual.sv
module rsq_qual
    import rsq_pkg::*;
#(
    parameter int unsigned FULL_QUAL = 10,
    parameter int unsigned SOLO_QUAL = 132
) (
    input  logic clk,
    input  logic rst,
    input  logic rst_in_n,
    input  logic halt_in_n,
    input  logic hold,
    input  logic booted,
    output logic both_asserted,
    output logic qualifying,
    output logic accept,
    output logic partial
);
    localparam int unsigned FCW = $clog2(FULL_QUAL + 1);
    localparam int unsigned SCW = $clog2(SOLO_QUAL + 1);

    logic [FCW-1:0] full_cnt;
    logic [SCW-1:0] solo_cnt;
    logic           solo_only;
    logic           full_hit;
    logic           solo_hit;
    logic           armed;

    assign both_asserted = ~rst_in_n & ~halt_in_n;
    assign solo_only     = ~rst_in_n & halt_in_n;
    assign qualifying    = ~rst_in_n & ~hold;

    assign full_hit = ~hold & both_asserted & (full_cnt == FCW'(FULL_QUAL - 1));
    assign solo_hit = ~hold & solo_only & booted & (solo_cnt == SCW'(SOLO_QUAL - 1));
    assign accept   = full_hit | solo_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            full_cnt <= '0;
            solo_cnt <= '0;
        end else if (!hold) begin
            full_cnt <= both_asserted ? FCW'(sat_next(int'(full_cnt), FULL_QUAL)) : '0;
            solo_cnt <= solo_only     ? SCW'(sat_next(int'(solo_cnt), SOLO_QUAL)) : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            armed   <= 1'b0;
            partial <= 1'b0;
        end else if (accept) begin
            armed   <= 1'b0;
            partial <= 1'b0;
        end else if (hold && both_asserted) begin
            armed   <= 1'b1;
        end else if (armed && !hold && !both_asserted) begin
            armed   <= 1'b0;
            partial <= 1'b1;
        end
    end

    AST_CNT_SATURATE: assert property (@(posedge clk) disable iff (rst)
        (full_cnt <= FCW'(FULL_QUAL)) && (solo_cnt <= SCW'(SOLO_QUAL))); // R10

    AST_HOLD_FREEZES: assert property (@(posedge clk) disable iff (rst)
        hold |=> (full_cnt == $past(full_cnt)) && (solo_cnt == $past(solo_cnt))); // R4

    AST_PARTIAL_NOT_ACCEPTED: assert property (@(posedge clk) disable iff (rst)
        $rose(partial) |-> !$past(accept)); // R5

endmodule

// File: rtl/rsq_swrst.sv
module rsq_swrst (
    input  logic clk,
    input  logic rst,
    input  logic sw_active,
    input  logic cycle_start,
    input  logic both_asserted,
    input  logic in_run,
    output logic drive
);
    logic sw_q;
    logic set_drive;
    logic clr_drive;

    assign set_drive = in_run & sw_active & ~sw_q;
    assign clr_drive = both_asserted | (cycle_start & ~sw_active);

    always_ff @(posedge clk) begin
        if (rst) begin
            sw_q  <= 1'b0;
            drive <= 1'b0;
        end else begin
            sw_q <= sw_active;
            if (drive) begin
                if (clr_drive) drive <= 1'b0;
            end else if (set_drive) begin
                drive <= 1'b1;
            end
        end
    end

    AST_DRIVE_NEEDS_RUN: assert property (@(posedge clk) disable iff (rst)
        $rose(drive) |-> $past(in_run)); // R6

endmodule

// File: rtl/rsq_vecseq.sv
module rsq_vecseq
    import rsq_pkg::*;
#(
    parameter int unsigned STARTUP_DLY = 4,
    parameter int unsigned ADDR_W      = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic              stall,
    input  logic              bus_ack,
    input  word_t             bus_rdata,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              fetch_req,
    output logic [2*WORD_W-1:0] sp_out,
    output logic [2*WORD_W-1:0] pc_out,
    output logic              core_in_reset,
    output logic              in_run,
    output logic              booted
);
    localparam int unsigned DCW = $clog2(STARTUP_DLY + 1);
    localparam int unsigned IW  = $clog2(VEC_WORDS);

    seq_state_e     state;
    logic [DCW-1:0] dly;
    logic [IW-1:0]  idx;
    vec_set_t       vset;

    assign rd_req        = (state == SEQ_VEC) & ~stall;
    assign fetch_req     = (state == SEQ_FETCH) & ~stall;
    assign rd_addr       = ADDR_W'(word_byte_addr(int'(idx)));
    assign in_run        = (state == SEQ_RUN);
    assign core_in_reset = ~in_run;
    assign sp_out        = in_run ? {vset.sp_hi, vset.sp_lo} : '0;
    assign pc_out        = in_run ? {vset.pc_hi, vset.pc_lo} : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= SEQ_BOOT;
            dly    <= '0;
            idx    <= '0;
            vset   <= '0;
            booted <= 1'b0;
        end else if (accept) begin
            state <= SEQ_START;
            dly   <= '0;
            idx   <= '0;
        end else begin
            case (state)
                SEQ_START: begin
                    if (dly == DCW'(STARTUP_DLY - 1)) state <= SEQ_VEC;
                    else                              dly   <= dly + 1'b1;
                end
                SEQ_VEC: begin
                    if (rd_req && bus_ack) begin
                        case (idx)
                            2'd0:    vset.sp_hi <= bus_rdata;
                            2'd1:    vset.sp_lo <= bus_rdata;
                            2'd2:    vset.pc_hi <= bus_rdata;
                            default: vset.pc_lo <= bus_rdata;
                        endcase
                        if (idx == IW'(VEC_WORDS - 1)) state <= SEQ_FETCH;
                        else                           idx   <= idx + 1'b1;
                    end
                end
                SEQ_FETCH: begin
                    if (!stall) begin
                        state  <= SEQ_RUN;
                        booted <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
        (rd_req && bus_ack && !accept && (idx != IW'(VEC_WORDS - 1)))
        |=> (rd_addr == $past(rd_addr) + ADDR_W'(WORD_BYTES))); // R7

    AST_FETCH_SINGLE: assert property (@(posedge clk) disable iff (rst)
        fetch_req |=> !fetch_req); // R8

    AST_RELEASE_AFTER_FETCH: assert property (@(posedge clk) disable iff (rst)
        $fell(core_in_reset) |-> $past(fetch_req)); // R8

endmodule

// File: rtl/rst_qual_seq.sv
module rst_qual_seq
    import rsq_pkg::*;
#(
    parameter int unsigned FULL_QUAL   = 10,
    parameter int unsigned SOLO_QUAL   = 132,
    parameter int unsigned STARTUP_DLY = 4,
    parameter int unsigned ADDR_W      = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ext_rst_n,
    input  logic                ext_halt_n,
    input  logic                sw_rst_active,
    input  logic                bus_cycle_start,
    input  logic                bus_ack,
    input  logic [WORD_W-1:0]   bus_rdata,
    output logic                rst_out_n,
    output logic                core_in_reset,
    output logic                partial_rst,
    output logic                rd_req,
    output logic [ADDR_W-1:0]   rd_addr,
    output logic                fetch_req,
    output logic [2*WORD_W-1:0] sp_out,
    output logic [2*WORD_W-1:0] pc_out
);
    logic drive;
    logic both_asserted;
    logic qualifying;
    logic accept;
    logic in_run;
    logic booted;

    assign rst_out_n = ~drive;

    rsq_swrst u_swrst (
        .clk           (clk),
        .rst           (rst),
        .sw_active     (sw_rst_active),
        .cycle_start   (bus_cycle_start),
        .both_asserted (both_asserted),
        .in_run        (in_run),
        .drive         (drive)
    );

    rsq_qual #(
        .FULL_QUAL (FULL_QUAL),
        .SOLO_QUAL (SOLO_QUAL)
    ) u_qual (
        .clk           (clk),
        .rst           (rst),
        .rst_in_n      (ext_rst_n),
        .halt_in_n     (ext_halt_n),
        .hold          (drive),
        .booted        (booted),
        .both_asserted (both_asserted),
        .qualifying    (qualifying),
        .accept        (accept),
        .partial       (partial_rst)
    );

    rsq_vecseq #(
        .STARTUP_DLY (STARTUP_DLY),
        .ADDR_W      (ADDR_W)
    ) u_vecseq (
        .clk           (clk),
        .rst           (rst),
        .accept        (accept),
        .stall         (qualifying),
        .bus_ack       (bus_ack),
        .bus_rdata     (bus_rdata),
        .rd_req        (rd_req),
        .rd_addr       (rd_addr),
        .fetch_req     (fetch_req),
        .sp_out        (sp_out),
        .pc_out        (pc_out),
        .core_in_reset (core_in_reset),
        .in_run        (in_run),
        .booted        (booted)
    );

    AST_BUS_QUIET_WHILE_QUAL: assert property (@(posedge clk) disable iff (rst)
        qualifying |-> (!rd_req && !fetch_req)); // R9

    AST_NO_ACCEPT_WHILE_DRIVING: assert property (@(posedge clk) disable iff (rst)
        !rst_out_n |-> !accept); // R4

    AST_SOLO_NEEDS_BOOT: assert property (@(posedge clk) disable iff (rst)
        (accept && !both_asserted) |-> booted); // R3

    AST_SW_RELEASE_ON_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (!rst_out_n && bus_cycle_start && !sw_rst_active) |=> rst_out_n); // R6

    AST_PAIR_RELEASES_OUTPUT: assert property (@(posedge clk) disable iff (rst)
        (!rst_out_n && !ext_rst_n && !ext_halt_n) |=> rst_out_n); // R5

endmodule

// File: tb/rst_qual_seq_bench.sv
module rst_qual_seq_bench;
    import rsq_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ext_rst_n = 1'b1;
    logic        ext_halt_n = 1'b1;
    logic        sw_rst_active = 1'b0;
    logic        bus_cycle_start = 1'b0;
    logic        bus_ack;
    logic [15:0] bus_rdata;
    logic        rst_out_n;
    logic        core_in_reset;
    logic        partial_rst;
    logic        rd_req;
    logic [7:0]  rd_addr;
    logic        fetch_req;
    logic [31:0] sp_out;
    logic [31:0] pc_out;

    int          n_checks = 0;
    int          n_fail = 0;
    int          waits = 0;
    int          wcnt = 0;
    logic [7:0]  seed = 8'h11;

    always #10 clk = ~clk;

    function automatic logic [15:0] vec_word(input logic [7:0] a, input logic [7:0] s);
        return {s, s} ^ {8'hC3, a};
    endfunction

    assign bus_rdata = vec_word(rd_addr, seed);
    assign bus_ack   = rd_req && (wcnt >= waits);

    always @(posedge clk) begin
        if (rst || !rd_req || bus_ack) wcnt <= 0;
        else                           wcnt <= wcnt + 1;
    end

    rst_qual_seq u_rst_qual_seq (
        .clk             (clk),
        .rst             (rst),
        .ext_rst_n       (ext_rst_n),
        .ext_halt_n      (ext_halt_n),
        .sw_rst_active   (sw_rst_active),
        .bus_cycle_start (bus_cycle_start),
        .bus_ack         (bus_ack),
        .bus_rdata       (bus_rdata),
        .rst_out_n       (rst_out_n),
        .core_in_reset   (core_in_reset),
        .partial_rst     (partial_rst),
        .rd_req          (rd_req),
        .rd_addr         (rd_addr),
        .fetch_req       (fetch_req),
        .sp_out          (sp_out),
        .pc_out          (pc_out)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_in(input bit r_n, input bit h_n);
        ext_rst_n  = r_n;
        ext_halt_n = h_n;
    endtask

    task automatic finish_seq(input string req);
        logic [7:0] seen [4];
        int k = 0;
        int guard = 0;
        while (!fetch_req && guard < 400) begin
            if (rd_req && bus_ack) begin
                if (k < 4) seen[k] = rd_addr;
                k++;
            end
            tick(1);
            guard++;
        end
        chk(fetch_req === 1'b1, {req, " R8 fetch strobe"}, 64'(fetch_req), 64'd1);
        chk(k == 4, {req, " R8 four reads before fetch"}, 64'(k), 64'd4);
        for (int i = 0; i < 4; i++)
            chk(seen[i] == 8'(2 * i), {req, " R7 read order"}, 64'(seen[i]), 64'(2 * i));
        tick(1);
        chk(fetch_req === 1'b0, {req, " R8 strobe single"}, 64'(fetch_req), 64'd0);
        chk(core_in_reset === 1'b0, {req, " R8 core released"}, 64'(core_in_reset), 64'd0);
        chk(sp_out === {vec_word(8'd0, seed), vec_word(8'd2, seed)}, {req, " R8 sp"},
            64'(sp_out), 64'({vec_word(8'd0, seed), vec_word(8'd2, seed)}));
        chk(pc_out === {vec_word(8'd4, seed), vec_word(8'd6, seed)}, {req, " R8 pc"},
            64'(pc_out), 64'({vec_word(8'd4, seed), vec_word(8'd6, seed)}));
    endtask

    initial begin
        #(20 * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        int solo_n [4] = '{1, 131, 132, 145};

        tick(3);
        // R1 reset state
        chk(rst_out_n === 1'b1, "R1 rst_out_n", 64'(rst_out_n), 64'd1);
        chk(core_in_reset === 1'b1, "R1 core_in_reset", 64'(core_in_reset), 64'd1);
        chk(partial_rst === 1'b0, "R1 partial_rst", 64'(partial_rst), 64'd0);
        chk({rd_req, fetch_req} === 2'b00, "R1 bus idle", 64'({rd_req, fetch_req}), 64'd0);
        chk({sp_out, pc_out} === 64'd0, "R1 vectors hidden", {sp_out, pc_out}, 64'd0);
        rst = 1'b0;
        tick(1);
        chk(core_in_reset === 1'b1 && rst_out_n === 1'b1, "R1 after reset",
            64'({core_in_reset, rst_out_n}), 64'd3);

        // R3: reset alone before first start-up is never accepted
        set_in(1'b0, 1'b1);
        tick(200);
        set_in(1'b1, 1'b1);
        tick(8);
        chk(rd_req === 1'b0, "R3 solo before boot ignored", 64'(rd_req), 64'd0);

        // R2: 9 edges of the pair is too short
        set_in(1'b0, 1'b0);
        tick(9);
        set_in(1'b1, 1'b1);
        tick(8);
        chk(rd_req === 1'b0, "R2 pair 9 edges rejected", 64'(rd_req), 64'd0);

        // R2 / R7: exactly 10 edges, delay timing
        set_in(1'b0, 1'b0);
        tick(10);
        chk(rd_req === 1'b0, "R9 bus quiet while held", 64'(rd_req), 64'd0);
        set_in(1'b1, 1'b1);
        tick(3);
        chk(rd_req === 1'b0, "R7 startup delay", 64'(rd_req), 64'd0);
        chk({sp_out, pc_out} === 64'd0, "R9 vectors hidden during sequence", {sp_out, pc_out}, 64'd0);
        tick(1);
        chk(rd_req === 1'b1 && rd_addr === 8'd0, "R7 first read after delay",
            64'({rd_req, rd_addr}), 64'h100);
        finish_seq("R2 boot");

        // R2 sweep of pair hold lengths in run state
        for (int n = 1; n <= 12; n++) begin
            set_in(1'b0, 1'b0);
            tick(n);
            chk(core_in_reset === (n >= 10), "R2 pair window", 64'(core_in_reset), 64'(n >= 10));
            chk(rd_req === 1'b0 && fetch_req === 1'b0, "R9 bus quiet while held",
                64'({rd_req, fetch_req}), 64'd0);
            set_in(1'b1, 1'b1);
            if (n >= 10) begin
                seed = 8'(n * 7);
                waits = n % 3;
                finish_seq("R2 sweep");
            end else begin
                tick(1);
            end
        end

        // R10: broken runs clear the counter
        set_in(1'b0, 1'b0);
        tick(6);
        set_in(1'b1, 1'b1);
        tick(1);
        set_in(1'b0, 1'b0);
        tick(6);
        chk(core_in_reset === 1'b0, "R10 counter cleared on negation", 64'(core_in_reset), 64'd0);
        set_in(1'b1, 1'b1);
        tick(1);

        // R3 / R10: reset alone after boot
        waits = 0;
        foreach (solo_n[j]) begin
            set_in(1'b0, 1'b1);
            tick(solo_n[j]);
            chk(core_in_reset === (solo_n[j] >= 132), "R3 solo window",
                64'(core_in_reset), 64'(solo_n[j] >= 132));
            set_in(1'b1, 1'b1);
            if (solo_n[j] == 145) begin
                #1;
                chk(rd_req === 1'b1 && rd_addr === 8'd0, "R10 single acceptance on long hold",
                    64'({rd_req, rd_addr}), 64'h100);
            end
            if (solo_n[j] >= 132) begin
                seed = 8'(solo_n[j]);
                finish_seq("R3 solo");
            end else begin
                tick(1);
            end
        end

        // R6 / R4: software reset output and ignored input
        sw_rst_active = 1'b1;
        tick(1);
        sw_rst_active = 1'b0;
        chk(rst_out_n === 1'b0, "R6 output driven", 64'(rst_out_n), 64'd0);
        tick(4);
        chk(rst_out_n === 1'b0, "R6 held until bus cycle", 64'(rst_out_n), 64'd0);
        set_in(1'b0, 1'b1);
        tick(150);
        chk(core_in_reset === 1'b0 && rst_out_n === 1'b0, "R4 input ignored while driving",
            64'({core_in_reset, rst_out_n}), 64'd0);
        set_in(1'b1, 1'b1);
        tick(1);
        bus_cycle_start = 1'b1;
        tick(1);
        bus_cycle_start = 1'b0;
        chk(rst_out_n === 1'b1, "R6 released at next bus cycle", 64'(rst_out_n), 64'd1);
        tick(2);

        // R5: pair during software reset, dropped early
        sw_rst_active = 1'b1;
        tick(1);
        sw_rst_active = 1'b0;
        set_in(1'b0, 1'b0);
        tick(1);
        chk(rst_out_n === 1'b1, "R5 output negated on pair", 64'(rst_out_n), 64'd1);
        tick(4);
        set_in(1'b1, 1'b1);
        tick(1);
        chk(partial_rst === 1'b1, "R5 partial flagged", 64'(partial_rst), 64'd1);
        chk(core_in_reset === 1'b0, "R5 partial not accepted", 64'(core_in_reset), 64'd0);
        set_in(1'b0, 1'b0);
        tick(10);
        chk(core_in_reset === 1'b1 && partial_rst === 1'b0, "R5 full reset clears partial",
            64'({core_in_reset, partial_rst}), 64'h2);
        set_in(1'b1, 1'b1);
        seed = 8'h5A;
        finish_seq("R5 recovery");

        // R11: abort in the middle of the vector reads
        waits = 3;
        seed = 8'h77;
        set_in(1'b0, 1'b0);
        tick(10);
        set_in(1'b1, 1'b1);
        for (int g = 0; g < 50 && !(rd_req && bus_ack); g++) tick(1);
        tick(2);
        set_in(1'b0, 1'b0);
        tick(1);
        chk(rd_req === 1'b0, "R9 reads stop while held", 64'(rd_req), 64'd0);
        tick(9);
        chk(core_in_reset === 1'b1, "R11 held in reset", 64'(core_in_reset), 64'd1);
        seed = 8'h3C;
        set_in(1'b1, 1'b1);
        tick(3);
        chk(rd_req === 1'b0, "R11 restart from delay", 64'(rd_req), 64'd0);
        finish_seq("R11 restart");

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule